// File: doc/BRIEF.md
# 4:2:2 Word Interleaver with Timing Reference Insertion

This block takes decimated component video (one luma sample per pixel, one Cb/Cr pair per two pixels) and emits a single 10-bit word stream on a line-locked clock running at twice the pixel rate. During active video it interleaves the components as Cb, Y, Cr, Y. Around each active region it emits four-word timing references (end of active video and start of active video). Between them it fills the horizontal blanking interval with alternating chroma-black and luma-black codes.

The timing references are not supplied from upstream. The block builds them from raw horizontal and vertical sync pulses. A word counter restarts on each horizontal sync rising edge and defines the horizontal blanking state. A vertical sync rising edge starts vertical blanking, which lasts a fixed number of lines. The position of that edge within the line decides the field flag. The stream is produced only when both the chroma-decimate control and the timing-insert control are high. A typical use is to feed a serializer or a parallel digital video port from a decoder back end.

Top module: `yc_stream_mux`

## Requirements
- R1: The stream is driven only while both `chroma_decimate` and `timing_insert` are high; when either is low, `stream_out` is 000h from the next clock edge on.
- R2: While `rst_n` is low, `stream_out` is 000h at every clock edge.
- R3: If `hsync` is sampled high at edge k after being low at edge k-1, the words 3FFh, 000h, 000h, XY(H=1) appear after edges k+1 to k+4. This is the end-of-active-video reference.
- R4: Every XY word has bit 9 = 1, bit 8 = F, bit 7 = V, bit 6 = H, bit 5 = V^H, bit 4 = F^H, bit 3 = F^V, bit 2 = F^V^H, and bits 1:0 = 0. This holds for all eight combinations of F, V and H.
- R5: Right after the end-of-active-video reference, HBLANK_FILL words alternate 200h then 040h, starting with 200h. After active video ends and until the next `hsync` edge, the alternation continues in the same word parity.
- R6: The start-of-active-video reference 3FFh, 000h, 000h, XY(H=0) follows the blanking fill directly. It begins HBLANK_FILL+4 words after the first word of the end-of-active-video reference.
- R7: ACTIVE_WORDS words of active video follow the start-of-active-video reference, ordered Cb, Y, Cr, Y. Each word is the matching input sampled at the edge that produces it. Input codes are assumed to lie in 004h to 3FBh.
- R8: A `vsync` rising edge sampled when the current word position (0 = first end-of-active-video word) is below HALF_WORDS sets F = 0. At or above HALF_WORDS it sets F = 1. The flags in the timing words change only at the next line start.
- R9: The timing words carry V = 1 on the VBL_LINES lines that follow the line in which `vsync` rose. They then return to V = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked clock at twice the pixel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| chroma_decimate | input | 1 | Chroma-decimate control; must be high to enable output |
| timing_insert | input | 1 | Timing-word insertion control; must be high to enable output |
| hsync | input | 1 | Horizontal sync pulse, rising edge starts a line |
| vsync | input | 1 | Vertical sync pulse, rising edge starts vertical blanking |
| y_in | input | 10 | Luma sample |
| cb_in | input | 10 | Blue colour-difference sample |
| cr_in | input | 10 | Red colour-difference sample |
| stream_out | output | 10 | Multiplexed word stream |

## Verification
A wrong word counter shows within one line: the 3FFh preamble, the fill parity or the Cb/Y/Cr/Y phase moves by a word. The bench's stream decoder catches this at the first misplaced word. A wrong field or vertical-blanking state only shows in the XY words of the following line or lines. The bench therefore steps vsync across the half-line boundary and counts blanking lines. It decodes every XY word and checks the protection bits, and confirms that all eight F/V/H combinations appeared.

// File: rtl/yc_stream_pkg.sv
// Shared constants and helpers for the 4:2:2 word interleaver.
// Assumes a 10-bit word width fixed by the stream format.
package yc_stream_pkg;

    localparam int WORD_W = 10;

    localparam logic [WORD_W-1:0] PRE_ONES  = 10'h3FF;
    localparam logic [WORD_W-1:0] PRE_ZERO  = 10'h000;
    localparam logic [WORD_W-1:0] BLK_CHROM = 10'h200;
    localparam logic [WORD_W-1:0] BLK_LUMA  = 10'h040;

    typedef enum logic [1:0] {
        RG_EAV,
        RG_FILL,
        RG_SAV,
        RG_ACT
    } line_region_t;

    // Build the fourth timing word from the field, vertical and horizontal flags.
    function automatic logic [WORD_W-1:0] make_xy(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
    endfunction

endpackage

// File: rtl/yc_line_timer.sv
// Horizontal word counter. It restarts at 0 on each hsync rising edge and
// saturates at LINE_END, the first word after active video. A parity bit
// keeps alternating after saturation so the blanking fill stays in step.
// Assumes hsync is synchronous to clk.
module yc_line_timer #(
    parameter int ACTIVE_WORDS = 1440,
    parameter int HBLANK_FILL  = 268,
    parameter int HCNT_W       = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync,
    output logic              hs_rise,
    output logic [HCNT_W-1:0] hcnt,
    output logic              par
);
    localparam int LINE_END = 8 + HBLANK_FILL + ACTIVE_WORDS;

    logic hs_q;

    // Delay hsync for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hs_q <= 1'b0;
        else        hs_q <= hsync;
    end

    assign hs_rise = hsync & ~hs_q;

    // Count words since the line start; saturate after active video.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= HCNT_W'(LINE_END);
            par  <= 1'b0;
        end else if (hs_rise) begin
            hcnt <= '0;
            par  <= 1'b0;
        end else begin
            par <= ~par;
            if (hcnt != HCNT_W'(LINE_END)) hcnt <= hcnt + 1'b1;
        end
    end

    // R3
    line_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_rise |=> (hcnt == '0 && !par));

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hcnt <= HCNT_W'(LINE_END));

endmodule

// File: rtl/yc_field_tracker.sv
// Derives the field and vertical-blanking state from vsync and latches both
// at each line start for use in that line's timing words. The field is
// chosen by where in the line the vsync rising edge falls.
// Assumes vsync is synchronous to clk.
module yc_field_tracker #(
    parameter int HALF_WORDS = 858,
    parameter int VBL_LINES  = 20,
    parameter int HCNT_W     = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync,
    input  logic              hs_rise,
    input  logic [HCNT_W-1:0] hcnt,
    output logic              line_f,
    output logic              line_v
);
    localparam int VC_W = $clog2(VBL_LINES + 1);

    logic            vs_q;
    logic            vs_rise;
    logic            field;
    logic            vblank;
    logic [VC_W-1:0] vcnt;

    // Delay vsync for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) vs_q <= 1'b0;
        else        vs_q <= vsync;
    end

    assign vs_rise = vsync & ~vs_q;

    // Track field, vertical blanking and its line count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field  <= 1'b0;
            vblank <= 1'b0;
            vcnt   <= '0;
        end else if (vs_rise) begin
            field  <= (hcnt >= HCNT_W'(HALF_WORDS));
            vblank <= 1'b1;
            vcnt   <= '0;
        end else if (hs_rise && vblank) begin
            if (vcnt == VC_W'(VBL_LINES - 1)) begin
                vblank <= 1'b0;
                vcnt   <= '0;
            end else begin
                vcnt <= vcnt + 1'b1;
            end
        end
    end

    // Freeze the flags for the whole line at its start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_f <= 1'b0;
            line_v <= 1'b0;
        end else if (hs_rise) begin
            line_f <= field;
            line_v <= vblank;
        end
    end

    // R8
    field_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vs_rise |=> (field == ($past(hcnt) >= HCNT_W'(HALF_WORDS))));

    // R9
    vblank_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vs_rise |=> vblank);

endmodule

// File: rtl/yc_word_select.sv
// Chooses the output word from the line position: timing references, the
// blanking fill, or the Cb/Y/Cr/Y interleave. It registers the result.
// Assumes HBLANK_FILL is a multiple of 4, so that the references and the
// active phase line up on 4-word boundaries.
module yc_word_select
    import yc_stream_pkg::*;
#(
    parameter int ACTIVE_WORDS = 1440,
    parameter int HBLANK_FILL  = 268,
    parameter int HCNT_W       = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [HCNT_W-1:0] hcnt,
    input  logic              par,
    input  logic              line_f,
    input  logic              line_v,
    input  logic [WORD_W-1:0] y_in,
    input  logic [WORD_W-1:0] cb_in,
    input  logic [WORD_W-1:0] cr_in,
    output logic [WORD_W-1:0] dout
);
    localparam int SAV_START = 4 + HBLANK_FILL;
    localparam int ACT_START = SAV_START + 4;
    localparam int LINE_END  = ACT_START + ACTIVE_WORDS;

    line_region_t      rg;
    logic [1:0]        ph;
    logic              is_xy;
    logic [WORD_W-1:0] word;

    // Decode the region of the line from the word counter.
    always_comb begin
        if (hcnt < HCNT_W'(4))              rg = RG_EAV;
        else if (hcnt < HCNT_W'(SAV_START)) rg = RG_FILL;
        else if (hcnt < HCNT_W'(ACT_START)) rg = RG_SAV;
        else if (hcnt < HCNT_W'(LINE_END))  rg = RG_ACT;
        else                                rg = RG_FILL;
    end

    assign ph    = hcnt[1:0] - 2'(SAV_START);
    assign is_xy = (rg == RG_EAV || rg == RG_SAV) && (ph == 2'd3);

    // Pick the word for the current position.
    always_comb begin
        word = PRE_ZERO;
        unique case (rg)
            RG_EAV, RG_SAV: begin
                unique case (ph)
                    2'd0:    word = PRE_ONES;
                    2'd3:    word = make_xy(line_f, line_v, rg == RG_EAV);
                    default: word = PRE_ZERO;
                endcase
            end
            RG_FILL: word = par ? BLK_LUMA : BLK_CHROM;
            RG_ACT: begin
                unique case (ph)
                    2'd0:    word = cb_in;
                    2'd2:    word = cr_in;
                    default: word = y_in;
                endcase
            end
            default: word = PRE_ZERO;
        endcase
    end

    // Register the stream; force zero when the mode is off.
    always_ff @(posedge clk) begin
        if (!rst_n)   dout <= '0;
        else if (!en) dout <= '0;
        else          dout <= word;
    end

    // R1
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (dout == '0));

    // R4
    xy_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_xy && en) |=> (dout[9] && dout[1:0] == 2'b00));

    // R4
    xy_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_xy && en) |=> (dout[5] == (dout[7] ^ dout[6]) && dout[4] == (dout[8] ^ dout[6])
                           && dout[3] == (dout[8] ^ dout[7])
                           && dout[2] == (dout[8] ^ dout[7] ^ dout[6])));

endmodule

// File: rtl/yc_stream_mux.sv
// Top level: 4:2:2 word interleaver with timing reference insertion on a
// line-locked clock at twice the pixel rate. It is enabled only when both
// mode controls are high. Assumes all inputs are synchronous to clk.
module yc_stream_mux #(
    parameter int ACTIVE_WORDS = 1440,
    parameter int HBLANK_FILL  = 268,
    parameter int HALF_WORDS   = 858,
    parameter int VBL_LINES    = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chroma_decimate,
    input  logic       timing_insert,
    input  logic       hsync,
    input  logic       vsync,
    input  logic [9:0] y_in,
    input  logic [9:0] cb_in,
    input  logic [9:0] cr_in,
    output logic [9:0] stream_out
);
    localparam int LINE_END = 8 + HBLANK_FILL + ACTIVE_WORDS;
    localparam int HCNT_W   = $clog2(LINE_END + 1);

    logic              hs_rise;
    logic [HCNT_W-1:0] hcnt;
    logic              par;
    logic              line_f;
    logic              line_v;
    logic              mode_on;

    assign mode_on = chroma_decimate & timing_insert;

    yc_line_timer #(
        .ACTIVE_WORDS(ACTIVE_WORDS),
        .HBLANK_FILL (HBLANK_FILL),
        .HCNT_W      (HCNT_W)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .hsync  (hsync),
        .hs_rise(hs_rise),
        .hcnt   (hcnt),
        .par    (par)
    );

    yc_field_tracker #(
        .HALF_WORDS(HALF_WORDS),
        .VBL_LINES (VBL_LINES),
        .HCNT_W    (HCNT_W)
    ) i_field (
        .clk    (clk),
        .rst_n  (rst_n),
        .vsync  (vsync),
        .hs_rise(hs_rise),
        .hcnt   (hcnt),
        .line_f (line_f),
        .line_v (line_v)
    );

    yc_word_select #(
        .ACTIVE_WORDS(ACTIVE_WORDS),
        .HBLANK_FILL (HBLANK_FILL),
        .HCNT_W      (HCNT_W)
    ) i_select (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (mode_on),
        .hcnt  (hcnt),
        .par   (par),
        .line_f(line_f),
        .line_v(line_v),
        .y_in  (y_in),
        .cb_in (cb_in),
        .cr_in (cr_in),
        .dout  (stream_out)
    );

endmodule

// File: tb/test_yc_stream_mux.sv
module test_yc_stream_mux;

    localparam int AW   = 16;
    localparam int HF   = 8;
    localparam int HALF = 18;
    localparam int VBL  = 2;
    localparam int SAV0 = 4 + HF;
    localparam int ACT0 = SAV0 + 4;
    localparam int LEND = ACT0 + AW;
    localparam int RUN  = LEND + 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cdec = 1'b1;
    logic       yuvt = 1'b1;
    logic       hsync = 1'b0;
    logic       vsync = 1'b0;
    logic [9:0] y_in = '0;
    logic [9:0] cb_in = '0;
    logic [9:0] cr_in = '0;
    logic [9:0] dout;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;
    bit  m_f = 1'b0;
    bit  m_v = 1'b0;
    int  m_vc = 0;
    bit [7:0] seen = '0;

    always #4 clk = ~clk;

    yc_stream_mux #(
        .ACTIVE_WORDS(AW),
        .HBLANK_FILL (HF),
        .HALF_WORDS  (HALF),
        .VBL_LINES   (VBL)
    ) i_yc_stream_mux (
        .clk            (clk),
        .rst_n          (rst_n),
        .chroma_decimate(cdec),
        .timing_insert  (yuvt),
        .hsync          (hsync),
        .vsync          (vsync),
        .y_in           (y_in),
        .cb_in          (cb_in),
        .cr_in          (cr_in),
        .stream_out     (dout)
    );

    function automatic logic [9:0] xy_ref(bit f, bit v, bit h);
        logic [9:0] w;
        w = '0;
        w[9] = 1'b1; w[8] = f; w[7] = v; w[6] = h;
        w[5] = v ^ h; w[4] = f ^ h; w[3] = f ^ v; w[2] = f ^ v ^ h;
        return w;
    endfunction

    function automatic bit prot_good(logic [9:0] w);
        return w[9] && w[1:0] == 2'b00 && w[5] == (w[7] ^ w[6]) && w[4] == (w[8] ^ w[6])
            && w[3] == (w[8] ^ w[7]) && w[2] == (w[8] ^ w[7] ^ w[6]);
    endfunction

    function automatic logic [9:0] fill_ref(int j);
        return (j % 2 == 0) ? 10'h200 : 10'h040;
    endfunction

    task automatic chk(string tag, logic [9:0] act, logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // One line: hsync pulse, then RUN words decoded against the model.
    task automatic run_line(input int vpos, input bit on);
        bit lf, lv;
        logic [9:0] exp;
        string tag;
        lf = m_f;
        lv = m_v;
        if (m_v) begin
            if (m_vc == VBL - 1) begin m_v = 1'b0; m_vc = 0; end
            else m_vc++;
        end
        hsync = 1'b1;
        @(negedge clk);
        hsync = 1'b0;
        for (int j = 0; j < RUN; j++) begin
            cb_in = 10'($urandom_range(1019, 4));
            y_in  = 10'($urandom_range(1019, 4));
            cr_in = 10'($urandom_range(1019, 4));
            if (vpos >= 0 && j >= vpos) vsync = 1'b1;
            if (j < 4) begin
                exp = (j == 0) ? 10'h3FF : (j == 3) ? xy_ref(lf, lv, 1'b1) : 10'h000;
                tag = (j == 3) ? "R4 R8 R9 EAV XY" : "R3 EAV preamble";
            end else if (j < SAV0) begin
                exp = fill_ref(j); tag = "R5 blank fill";
            end else if (j < ACT0) begin
                exp = (j == SAV0) ? 10'h3FF : (j == SAV0 + 3) ? xy_ref(lf, lv, 1'b0) : 10'h000;
                tag = "R6 SAV word";
            end else if (j < LEND) begin
                case ((j - ACT0) % 4)
                    0: exp = cb_in;
                    2: exp = cr_in;
                    default: exp = y_in;
                endcase
                tag = "R7 active order";
            end else begin
                exp = fill_ref(j); tag = "R5 post-active fill";
            end
            if (!on) begin exp = '0; tag = "R1 mode off"; end
            @(negedge clk);
            chk(tag, dout, exp);
            if (on && (j == 3 || j == SAV0 + 3)) begin
                checks++;
                if (!prot_good(dout)) begin
                    fails++;
                    $display("FAIL R4 protection: got %h expected %h", dout, xy_ref(dout[8], dout[7], dout[6]));
                end
                seen[dout[8:6]] = 1'b1;
            end
        end
        vsync = 1'b0;
        if (vpos >= 0) begin
            m_f = (vpos >= HALF);
            m_v = 1'b1;
            m_vc = 0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        chk("R2 reset value", dout, 10'h000);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed: walk through all F/V/H combinations.
        run_line(-1, 1'b1);
        run_line(-1, 1'b1);
        run_line(5, 1'b1);          // R8 first half -> F=0
        run_line(-1, 1'b1);         // R9 V=1
        run_line(-1, 1'b1);         // R9 V=1
        run_line(-1, 1'b1);         // V back to 0
        run_line(HALF, 1'b1);       // R8 boundary -> F=1
        run_line(-1, 1'b1);
        run_line(-1, 1'b1);
        run_line(-1, 1'b1);
        run_line(HALF - 1, 1'b1);   // R8 just below boundary -> F=0
        run_line(-1, 1'b1);
        // R1: each control alone disables the stream.
        cdec = 1'b0;
        run_line(-1, 1'b0);
        cdec = 1'b1; yuvt = 1'b0;
        run_line(-1, 1'b0);
        yuvt = 1'b1;
        run_line(-1, 1'b1);
        // Random vsync placement.
        for (int n = 0; n < 16; n++) begin
            int vp;
            vp = ($urandom_range(2, 0) == 0) ? int'($urandom_range(RUN - 1, 0)) : -1;
            run_line(vp, 1'b1);
        end
        checks++;
        if (seen != 8'hFF) begin
            fails++;
            $display("FAIL R4 combinations seen: got %h expected ff", seen);
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule